// File: doc/BRIEF.md
# Write-once watchdog control register

This block is the byte-wide control register that configures a watchdog timer. It sits on a simple register bus with an address, a write strobe, write data and combinational read data. It holds three fields that it passes straight to the watchdog core: a windowed-service enable, a set-only flag that halts the watchdog while a debugger holds the processor, and a 3-bit timeout rate select.

A mode input chooses between two sets of write rules. In special mode, which is used for test and debug, every field can be rewritten as often as needed. In normal mode, the enable and the rate select accept only the first write after reset. That first write locks both fields even when the values it carries have no effect. The debug-halt flag can only be set in normal mode.

Bit 5 of the write data is a write mask. When it is set, a write can change the debug-halt flag without touching the locked fields or using up the single normal-mode write. The block has no counter, no service sequence and no reset generation.

Top module: `wdc_ctl_reg`

## Requirements
- R1: After a synchronous reset, win_enable equals parameter WIN_RST, rate_sel equals parameter RATE_RST, and dbg_stop and lock_status are both 0.
- R2: When bus_addr equals REG_ADDR, bus_rdata shows the fields in every mode and at any time. The layout is bit 7 = win_enable, bit 6 = dbg_stop, bits 2:0 = rate_sel, and bits 5:3 read as 0.
- R3: In special mode, an unmasked write loads win_enable from data bit 7 and rate_sel from data bits 2:0, including zero values. It leaves lock_status unchanged.
- R4: In normal mode, the first unmasked write sets lock_status to 1. If data bit 7 is 1, it sets win_enable. If data bits 2:0 are nonzero, it loads them into rate_sel.
- R5: In normal mode, writing 000 to the rate bits leaves rate_sel unchanged, but the write still sets lock_status.
- R6: In normal mode, writing 0 to data bit 7 leaves win_enable unchanged, but the write still sets lock_status.
- R7: While lock_status is 1, normal-mode writes do not change win_enable or rate_sel. Only reset clears lock_status.
- R8: Data bit 6 drives dbg_stop. In special mode a write sets or clears dbg_stop. In normal mode a 1 sets it, and a 0 is ignored.
- R9: When data bit 5 is 1, win_enable, rate_sel and lock_status keep their values. dbg_stop still follows R8.
- R10: lock_status reports whether the single normal-mode write has been used.
- R11: A write to any address other than REG_ADDR changes nothing, and a read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 selects the unrestricted write rules |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| win_enable | output | 1 | Windowed-service enable to the watchdog core |
| dbg_stop | output | 1 | Halt the watchdog during debug |
| rate_sel | output | 3 | Timeout rate select |
| lock_status | output | 1 | The normal-mode write has been used |

## Verification
The assertions check the following on every cycle:
- lock_status never clears outside reset.
- Locked fields hold still in normal mode.
- dbg_stop never falls in normal mode.
- A masked write leaves the protected state alone.
- A special-mode write lands exactly.
- The reserved read bits stay 0.

Only the bench's scenarios show the following:
- The first-write behaviour in normal mode across all 256 data bytes, including how zero fields are ignored yet still lock.
- The interplay between a masked first write and a later locking write.
- The reset values and the decoding of foreign addresses.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    localparam int DATA_W   = 8;
    localparam int RATE_W   = 3;
    localparam int BIT_WIN  = 7;
    localparam int BIT_DBG  = 6;
    localparam int BIT_MASK = 5;
    localparam int RATE_LSB = 0;

    typedef logic [RATE_W-1:0] rate_t;

    typedef struct packed {
        logic  win;
        logic  dbg;
        rate_t rate;
    } wdc_fields_t;

    typedef struct packed {
        logic  hit;
        logic  mask;
        logic  win;
        logic  dbg;
        rate_t rate;
    } wdc_req_t;

    function automatic wdc_req_t split_write(input logic hit, input logic [DATA_W-1:0] d);
        wdc_req_t r;
        r.hit  = hit;
        r.mask = d[BIT_MASK];
        r.win  = d[BIT_WIN];
        r.dbg  = d[BIT_DBG];
        r.rate = d[RATE_LSB +: RATE_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] join_read(input wdc_fields_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_WIN] = f.win;
        v[BIT_DBG] = f.dbg;
        v[RATE_LSB +: RATE_W] = f.rate;
        return v;
    endfunction
endpackage

// File: rtl/wdc_bus_decode.sv
module wdc_bus_decode
    import wdc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              sel,
    output wdc_req_t          req
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    always_comb begin
        sel = (bus_addr == MY_ADDR);
        req = split_write(sel && bus_wr, bus_wdata);
    end
endmodule

// File: rtl/wdc_field_store.sv
module wdc_field_store
    import wdc_pkg::*;
#(
    parameter logic        WIN_RST  = 1'b0,
    parameter logic [2:0]  RATE_RST = 3'd7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        special_mode,
    input  wdc_req_t    req,
    output wdc_fields_t fields,
    output logic        locked
);
    localparam rate_t RATE_ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields.win  <= WIN_RST;
            fields.dbg  <= 1'b0;
            fields.rate <= rate_t'(RATE_RST);
            locked      <= 1'b0;
        end else if (req.hit) begin
            // debug-halt flag: free in special mode, set-only otherwise
            if (special_mode)
                fields.dbg <= req.dbg;
            else if (req.dbg)
                fields.dbg <= 1'b1;

            if (!req.mask) begin
                if (special_mode) begin
                    fields.win  <= req.win;
                    fields.rate <= req.rate;
                end else if (!locked) begin
                    if (req.win)
                        fields.win <= 1'b1;
                    if (req.rate != RATE_ZERO)
                        fields.rate <= req.rate;
                    locked <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdc_readback.sv
module wdc_readback
    import wdc_pkg::*;
(
    input  logic              sel,
    input  wdc_fields_t       fields,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = sel ? join_read(fields) : '0;
    end
endmodule

// File: rtl/wdc_ctl_reg.sv
module wdc_ctl_reg
    import wdc_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          REG_ADDR = 8,
    parameter logic        WIN_RST  = 1'b0,
    parameter logic [2:0]  RATE_RST = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              win_enable,
    output logic              dbg_stop,
    output logic [2:0]        rate_sel,
    output logic              lock_status
);
    logic        sel;
    wdc_req_t    req;
    wdc_fields_t fields;
    logic        locked;

    wdc_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .req      (req)
    );

    wdc_field_store #(.WIN_RST(WIN_RST), .RATE_RST(RATE_RST)) u_store (
        .clk         (clk),
        .rst         (rst),
        .special_mode(special_mode),
        .req         (req),
        .fields      (fields),
        .locked      (locked)
    );

    wdc_readback u_rb (
        .sel   (sel),
        .fields(fields),
        .rdata (bus_rdata)
    );

    assign win_enable  = fields.win;
    assign dbg_stop    = fields.dbg;
    assign rate_sel    = fields.rate;
    assign lock_status = locked;
endmodule

// File: rtl/wdc_ctl_chk.sv
module wdc_ctl_chk #(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              special_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              win_enable,
    input logic              dbg_stop,
    input logic [2:0]        rate_sel,
    input logic              lock_status
);
    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[5:3] == 3'b000);

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        lock_status |=> lock_status);

    p_locked_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (lock_status && !special_mode) |=> ($stable(win_enable) && $stable(rate_sel)));

    p_dbg_setonly_r8: assert property (@(posedge clk) disable iff (rst)
        (dbg_stop && !special_mode) |=> dbg_stop);

    p_mask_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_wdata[5]) |=> ($stable(win_enable) && $stable(rate_sel) && $stable(lock_status)));

    p_special_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && special_mode && !bus_wdata[5]) |=>
        (win_enable == $past(bus_wdata[7]) && rate_sel == $past(bus_wdata[2:0]) && $stable(lock_status)));

    p_zero_rate_locks_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !special_mode && !bus_wdata[5] && !lock_status && bus_wdata[2:0] == 3'b000) |=>
        ($stable(rate_sel) && lock_status));
endmodule

bind wdc_ctl_reg wdc_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk(clk), .rst(rst), .special_mode(special_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_enable(win_enable), .dbg_stop(dbg_stop), .rate_sel(rate_sel),
    .lock_status(lock_status)
);

// File: tb/wdc_ctl_reg_tb.sv
module wdc_ctl_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int REG_ADDR   = 8;
    localparam logic       WIN_RST  = 1'b0;
    localparam logic [2:0] RATE_RST = 3'd7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              special_mode = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              win_enable, dbg_stop, lock_status;
    logic [2:0]        rate_sel;

    int checks = 0;
    int fails  = 0;

    // bench-side expected state
    logic       m_win, m_dbg, m_lock;
    logic [2:0] m_rate;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdc_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WIN_RST(WIN_RST), .RATE_RST(RATE_RST)) u_dut (
        .clk(clk), .rst(rst), .special_mode(special_mode), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_enable(win_enable), .dbg_stop(dbg_stop), .rate_sel(rate_sel),
        .lock_status(lock_status)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_win = WIN_RST; m_rate = RATE_RST; m_dbg = 1'b0; m_lock = 1'b0;
    endtask

    // expected effect of a write, derived from the requirement list
    task automatic model_write(input logic sp, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        if (a != ADDR_W'(REG_ADDR)) return;
        if (sp) m_dbg = d[6];
        else if (d[6]) m_dbg = 1'b1;
        if (!d[5]) begin
            if (sp) begin
                m_win = d[7]; m_rate = d[2:0];
            end else if (!m_lock) begin
                if (d[7]) m_win = 1'b1;
                if (d[2:0] != 3'b000) m_rate = d[2:0];
                m_lock = 1'b1;
            end
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(special_mode, a, d);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " win_enable"},  {7'd0, win_enable},  {7'd0, m_win});
        chk({tag, " rate_sel"},    {5'd0, rate_sel},    {5'd0, m_rate});
        chk({tag, " R8 dbg_stop"}, {7'd0, dbg_stop},    {7'd0, m_dbg});
        chk({tag, " R10 lock"},    {7'd0, lock_status}, {7'd0, m_lock});
        bus_addr = ADDR_W'(REG_ADDR);
        #1;
        chk({tag, " R2 readback"}, bus_rdata, {m_win, m_dbg, 3'b000, m_rate});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        check_all("R1 reset");

        // R3 / R8 / R9: every byte in special mode
        special_mode = 1'b1;
        for (int d = 0; d < 256; d++) begin
            bus_write(ADDR_W'(REG_ADDR), 8'(d));
            check_all(d[5] ? "R9 special masked" : "R3 special");
        end

        // R4 R5 R6 R7 R9: first and second write in normal mode for every byte
        special_mode = 1'b0;
        for (int d = 0; d < 256; d++) begin
            do_reset();
            bus_write(ADDR_W'(REG_ADDR), 8'(d));
            if (d[5])                 check_all("R9 normal masked");
            else if (d[2:0] == 3'b0)  check_all("R5 zero rate locks");
            else if (!d[7])           check_all("R6 zero win locks");
            else                      check_all("R4 first write");
            bus_write(ADDR_W'(REG_ADDR), (~8'(d)) & 8'hDF);
            check_all("R7 second write");
            bus_write(ADDR_W'(REG_ADDR), 8'h00);
            check_all("R8 clear ignored");
        end

        // R11: foreign address
        do_reset();
        bus_write(ADDR_W'(REG_ADDR + 1), 8'hC5);
        check_all("R11 foreign write");
        bus_addr = ADDR_W'(REG_ADDR + 1);
        #1;
        chk("R11 foreign read", bus_rdata, 8'h00);

        // R8 special clear after set
        special_mode = 1'b1;
        bus_write(ADDR_W'(REG_ADDR), 8'h40);
        bus_write(ADDR_W'(REG_ADDR), 8'h00);
        check_all("R8 special clear");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule